// File: doc/BRIEF.md
# CAN Frame Timestamp Unit

This block keeps a free-running 16-bit time base for a CAN controller and stamps successfully completed frames with it. The time base advances on nominal bit-time ticks delivered by the bit-timing logic, slowed down by a 4-bit programmable divider: with divider value P the count moves once every P+1 ticks, so the reset value of zero gives one step per bit.

When the protocol engine reports that a frame has completed successfully, the live count is first frozen in a hold register. A write strobe for the message mailbox follows, and the stamp offered to the mailbox always comes from the hold register, so it cannot change while it is being written. A receiving node judges success one bit earlier than a transmitting node: a receiver only needs a clean frame up to the final End-of-Frame bit, while a transmitter needs it through that bit. A wrap of the count raises an interrupt flag and a matching status flag; one write-one-to-clear action on the interrupt flag clears both.

A small word-wide register port gives software access to the divider, the count and the two flags.

Top module: `tstamp_unit`

## Requirements
- R1: The divider register at address 0 holds a 4-bit value in bits 3:0, resets to 0, is readable and writable, and bits 31:4 always read as 0.
- R2: The count register at address 1 returns the 16-bit count in bits 15:0 with bits 31:16 as 0, resets to 0, and writes to it have no effect.
- R3: With divider value P, the first tick after reset advances the count, and after that the count advances once every P+1 ticks; cycles without a tick never change it.
- R4: A new divider value written by software takes effect only when the current divide period has run out; the period already under way finishes with the old value.
- R5: The count wraps from 0xFFFF to 0x0000; the wrap sets the interrupt flag (address 2, bit 0) and the status flag (address 3, bit 0), and the interrupt output follows the interrupt flag.
- R6: Writing 1 to bit 0 at address 2 clears both flags; writing 0 there, or any value at address 3, leaves them unchanged.
- R7: When a wrap and a clearing write fall in the same cycle, both flags end up set.
- R8: On a receiver (transmit-role input low), a pulse on the before-last End-of-Frame bit input while the error input is low loads the hold register with the count; an error reported afterwards does not cancel it, and the last-bit input never triggers a receiver capture.
- R9: On a transmitter (transmit-role input high), a pulse on the last End-of-Frame bit input while the error input is low loads the hold register; with the error input high no capture takes place, and the before-last input never triggers a transmitter capture.
- R10: The mailbox write strobe is high for exactly one cycle, one cycle after the hold register is loaded; the stamp output shows the hold register and stays unchanged while the count keeps moving.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle pulse per nominal bit time |
| node_is_tx | input | 1 | High while this node transmits the current frame |
| frame_err | input | 1 | High once an error has been seen in the current frame |
| eof_before_last | input | 1 | Pulse at the end of the second-to-last End-of-Frame bit |
| eof_last | input | 1 | Pulse at the end of the final End-of-Frame bit |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| stamp | output | 16 | Captured stamp from the hold register |
| stamp_wr | output | 1 | One-cycle mailbox write strobe |
| wrap_irq | output | 1 | Interrupt request from the wrap flag |

## Verification
The hardest situation to reach is a wrap landing in the very cycle of a clearing write while the flags are already set, because the count must be walked to 0xFFFF and the write aligned to the tick that wraps it. The bench holds the tick high with the divider at zero for exactly 65535 cycles after the first wrap, then raises the tick and the clearing write on the same edge. The difference between receiver and transmitter success is reached by raising the error input between the two End-of-Frame pulses, so the same frame end stamps on one role and not on the other.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADR_DIV   = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_COUNT = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_IFLAG = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_STAT  = 2'd3;
endpackage

// File: rtl/tstamp_divider.sv
module tstamp_divider #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [DIV_W-1:0] reload_i,
    output logic             step_o
);
    typedef struct packed {
        logic [DIV_W-1:0] remain;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        step_o = tick_i && (st_q.remain == '0);
        if (tick_i) begin
            if (st_q.remain == '0) begin
                st_d.remain = reload_i;
            end else begin
                st_d.remain = st_q.remain - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tstamp_timebase.sv
module tstamp_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             clear_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o,
    output logic             irq_flag_o,
    output logic             stat_flag_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             irq_flag;
        logic             stat_flag;
    } tb_state_t;

    tb_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        wrap_o = step_i && (st_q.count == CNT_MAX);
        if (step_i) begin
            st_d.count = st_q.count + 1'b1;
        end
        if (clear_i) begin
            st_d.irq_flag  = 1'b0;
            st_d.stat_flag = 1'b0;
        end
        if (wrap_o) begin
            st_d.irq_flag  = 1'b1;
            st_d.stat_flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o     = st_q.count;
    assign irq_flag_o  = st_q.irq_flag;
    assign stat_flag_o = st_q.stat_flag;
endmodule

// File: rtl/tstamp_capture.sv
module tstamp_capture #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_tx_i,
    input  logic             err_i,
    input  logic             eof_prev_i,
    input  logic             eof_last_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             take_o,
    output logic [CNT_W-1:0] hold_o,
    output logic             strobe_o
);
    typedef struct packed {
        logic [CNT_W-1:0] hold;
        logic             pending;
        logic             strobe;
    } cap_state_t;

    cap_state_t st_d, st_q;
    logic rx_ok, tx_ok;

    always_comb begin
        st_d   = st_q;
        rx_ok  = !is_tx_i && eof_prev_i && !err_i;
        tx_ok  = is_tx_i && eof_last_i && !err_i;
        take_o = rx_ok || tx_ok;
        if (take_o) begin
            st_d.hold = count_i;
        end
        st_d.pending = take_o;
        st_d.strobe  = st_q.pending;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_o   = st_q.hold;
    assign strobe_o = st_q.strobe;
endmodule

// File: rtl/tstamp_unit.sv
module tstamp_unit
    import tstamp_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DIV_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              node_is_tx,
    input  logic              frame_err,
    input  logic              eof_before_last,
    input  logic              eof_last,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [CNT_W-1:0]  stamp,
    output logic              stamp_wr,
    output logic              wrap_irq
);
    typedef struct packed {
        logic [DIV_W-1:0] div_val;
    } reg_state_t;

    reg_state_t rs_d, rs_q;

    logic             step_w;
    logic             clear_w;
    logic             wrap_w;
    logic             take_w;
    logic             irq_flag_w;
    logic             stat_flag_w;
    logic [CNT_W-1:0] count_w;

    always_comb begin
        rs_d    = rs_q;
        clear_w = 1'b0;
        if (reg_wr) begin
            case (reg_addr)
                ADR_DIV:   rs_d.div_val = reg_wdata[DIV_W-1:0];
                ADR_IFLAG: clear_w      = reg_wdata[0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADR_DIV:   reg_rdata[DIV_W-1:0] = rs_q.div_val;
            ADR_COUNT: reg_rdata[CNT_W-1:0] = count_w;
            ADR_IFLAG: reg_rdata[0]         = irq_flag_w;
            ADR_STAT:  reg_rdata[0]         = stat_flag_w;
            default:   reg_rdata            = '0;
        endcase
    end

    tstamp_divider #(.DIV_W(DIV_W)) i_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (bit_tick),
        .reload_i (rs_q.div_val),
        .step_o   (step_w)
    );

    tstamp_timebase #(.CNT_W(CNT_W)) i_base (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_i      (step_w),
        .clear_i     (clear_w),
        .count_o     (count_w),
        .wrap_o      (wrap_w),
        .irq_flag_o  (irq_flag_w),
        .stat_flag_o (stat_flag_w)
    );

    tstamp_capture #(.CNT_W(CNT_W)) i_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .is_tx_i    (node_is_tx),
        .err_i      (frame_err),
        .eof_prev_i (eof_before_last),
        .eof_last_i (eof_last),
        .count_i    (count_w),
        .take_o     (take_w),
        .hold_o     (stamp),
        .strobe_o   (stamp_wr)
    );

    assign wrap_irq = irq_flag_w;
endmodule

// File: rtl/tstamp_checker.sv
module tstamp_checker #(
    parameter int CNT_W = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              node_is_tx,
    input logic              frame_err,
    input logic              eof_before_last,
    input logic              eof_last,
    input logic              reg_wr,
    input logic [1:0]        reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [CNT_W-1:0]  stamp,
    input logic              stamp_wr,
    input logic              wrap_irq,
    input logic              step_w,
    input logic [CNT_W-1:0]  count_w,
    input logic              stat_flag_w
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic at_max_step, w1c;
    assign at_max_step = step_w && (count_w == CNT_MAX);
    assign w1c         = reg_wr && (reg_addr == 2'd2) && reg_wdata[0];

    p_div_upper_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd0) |-> (reg_rdata[DATA_W-1:4] == '0));

    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (count_w != $past(count_w)) |-> (count_w == CNT_W'($past(count_w) + 1'b1)));

    p_wrap_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        at_max_step |=> (wrap_irq && stat_flag_w && count_w == '0));

    p_flags_agree_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_irq == stat_flag_w);

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c && !at_max_step) |=> !wrap_irq);

    p_wrap_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c && at_max_step) |=> wrap_irq);

    p_rx_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eof_before_last && !node_is_tx && !frame_err) |=> (stamp == $past(count_w)));

    p_tx_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (eof_last && node_is_tx && !frame_err) |=> (stamp == $past(count_w)));

    p_strobe_late_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((eof_before_last && !node_is_tx && !frame_err) ||
         (eof_last && node_is_tx && !frame_err)) |-> ##2 stamp_wr);

    p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stamp_wr |=> !stamp_wr);

    p_stamp_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stamp_wr |-> $stable(stamp));
endmodule

bind tstamp_unit tstamp_checker #(.CNT_W(CNT_W), .DATA_W(tstamp_pkg::DATA_W)) i_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .node_is_tx      (node_is_tx),
    .frame_err       (frame_err),
    .eof_before_last (eof_before_last),
    .eof_last        (eof_last),
    .reg_wr          (reg_wr),
    .reg_addr        (reg_addr),
    .reg_wdata       (reg_wdata),
    .reg_rdata       (reg_rdata),
    .stamp           (stamp),
    .stamp_wr        (stamp_wr),
    .wrap_irq        (wrap_irq),
    .step_w          (step_w),
    .count_w         (count_w),
    .stat_flag_w     (stat_flag_w)
);

// File: tb/test_tstamp_unit.sv
`timescale 1ns/1ps
module test_tstamp_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b0;
    logic        node_is_tx = 1'b0;
    logic        frame_err = 1'b0;
    logic        eof_before_last = 1'b0;
    logic        eof_last = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] stamp;
    logic        stamp_wr;
    logic        wrap_irq;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    tstamp_unit i_tstamp_unit (
        .clk             (clk),
        .rst_n           (rst_n),
        .bit_tick        (bit_tick),
        .node_is_tx      (node_is_tx),
        .frame_err       (frame_err),
        .eof_before_last (eof_before_last),
        .eof_last        (eof_last),
        .reg_wr          (reg_wr),
        .reg_addr        (reg_addr),
        .reg_wdata       (reg_wdata),
        .reg_rdata       (reg_rdata),
        .stamp           (stamp),
        .stamp_wr        (stamp_wr),
        .wrap_irq        (wrap_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic tick_once();
        @(negedge clk);
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
    endtask

    task automatic tick_run(input int n);
        @(negedge clk);
        bit_tick = 1'b1;
        repeat (n) @(negedge clk);
        bit_tick = 1'b0;
    endtask

    // watch strobe for n cycles, expecting it to stay low
    task automatic quiet(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(req, {31'd0, stamp_wr}, 32'd0);
        end
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;

        // reset state
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1/R2 reset", v, 32'd0);
        end
        chk("R10 reset strobe", {31'd0, stamp_wr}, 32'd0);
        chk("R5 reset irq", {31'd0, wrap_irq}, 32'd0);

        // R1 divider field width and read-back
        wr(2'd0, 32'hFFFF_FFF5);
        rd(2'd0, v); chk("R1 divider masked", v, 32'h5);
        wr(2'd0, 32'h0);
        rd(2'd0, v); chk("R1 divider zero", v, 32'h0);

        // R2 count register ignores writes
        wr(2'd1, 32'hABCD_1234);
        rd(2'd1, v); chk("R2 write ignored", v, 32'h0);

        // R3 sweep over every divider value
        for (int p = 0; p < 16; p++) begin
            do_reset();
            wr(2'd0, 32'(p));
            repeat (3) @(negedge clk);
            rd(2'd1, v); chk("R3 no tick no step", v, 32'd0);
            for (int k = 1; k <= 2 * (p + 1) + 1; k++) begin
                tick_once();
                rd(2'd1, v);
                chk("R3 divided count", v, 32'(1 + (k - 1) / (p + 1)));
            end
        end

        // R4 new divider only at the next reload
        do_reset();
        wr(2'd0, 32'd3);
        tick_once();
        rd(2'd1, v); chk("R4 first step", v, 32'd1);
        wr(2'd0, 32'd0);
        for (int k = 2; k <= 6; k++) begin
            tick_once();
            rd(2'd1, v);
            chk("R4 old period finishes", v, (k <= 4) ? 32'd1 : 32'(k - 3));
        end

        // R5 wrap, R6 clear rules, R7 collision
        do_reset();
        tick_run(65535);
        rd(2'd1, v); chk("R5 at max", v, 32'hFFFF);
        chk("R5 no irq before wrap", {31'd0, wrap_irq}, 32'd0);
        tick_once();
        rd(2'd1, v); chk("R5 wrapped", v, 32'h0);
        chk("R5 irq", {31'd0, wrap_irq}, 32'd1);
        rd(2'd2, v); chk("R5 irq flag", v, 32'd1);
        rd(2'd3, v); chk("R5 status flag", v, 32'd1);
        wr(2'd2, 32'hFFFF_FFFE);
        rd(2'd2, v); chk("R6 zero write keeps irq flag", v, 32'd1);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, v); chk("R6 status write ignored", v, 32'd1);
        chk("R6 irq still up", {31'd0, wrap_irq}, 32'd1);
        // count is 0; 65535 more ticks reach 0xFFFF with flags still set
        tick_run(65535);
        rd(2'd1, v); chk("R7 at max again", v, 32'hFFFF);
        @(negedge clk);
        bit_tick = 1'b1; reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 32'd1;
        @(negedge clk);
        bit_tick = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        rd(2'd1, v); chk("R7 wrapped", v, 32'h0);
        rd(2'd2, v); chk("R7 wrap beats clear irq", v, 32'd1);
        rd(2'd3, v); chk("R7 wrap beats clear status", v, 32'd1);
        wr(2'd2, 32'd1);
        rd(2'd2, v); chk("R6 clear irq flag", v, 32'd0);
        rd(2'd3, v); chk("R6 clear status flag", v, 32'd0);
        chk("R6 irq low", {31'd0, wrap_irq}, 32'd0);

        // R8 receiver stamps at before-last bit; late error does not cancel
        do_reset();
        tick_run(37);
        @(negedge clk);
        node_is_tx = 1'b0; frame_err = 1'b0; eof_before_last = 1'b1;
        @(negedge clk);
        eof_before_last = 1'b0; frame_err = 1'b1; bit_tick = 1'b1;
        chk("R8 rx stamp", {16'd0, stamp}, 32'd37);
        chk("R10 strobe not yet", {31'd0, stamp_wr}, 32'd0);
        @(negedge clk);
        eof_last = 1'b1;
        chk("R10 strobe", {31'd0, stamp_wr}, 32'd1);
        chk("R10 stamp held", {16'd0, stamp}, 32'd37);
        rd(2'd1, v); chk("R10 count moved on", v, 32'd38);
        @(negedge clk);
        eof_last = 1'b0; bit_tick = 1'b0; frame_err = 1'b0;
        chk("R10 strobe one cycle", {31'd0, stamp_wr}, 32'd0);
        quiet("R8 rx ignores last-bit pulse", 2);
        rd(2'd1, v); chk("R8 count", v, 32'd39);

        // R9 transmitter: before-last pulse ignored, error at last bit cancels
        @(negedge clk);
        node_is_tx = 1'b1; eof_before_last = 1'b1;
        @(negedge clk);
        eof_before_last = 1'b0; frame_err = 1'b1; eof_last = 1'b1;
        @(negedge clk);
        eof_last = 1'b0; frame_err = 1'b0;
        quiet("R9 tx no stamp", 3);
        chk("R9 stamp unchanged", {16'd0, stamp}, 32'd37);

        // R9 transmitter clean frame
        @(negedge clk);
        eof_last = 1'b1;
        @(negedge clk);
        eof_last = 1'b0;
        chk("R9 tx stamp", {16'd0, stamp}, 32'd39);
        chk("R10 tx strobe not yet", {31'd0, stamp_wr}, 32'd0);
        @(negedge clk);
        chk("R10 tx strobe", {31'd0, stamp_wr}, 32'd1);

        // R8 receiver with earlier error: no stamp
        tick_run(5);
        @(negedge clk);
        node_is_tx = 1'b0; frame_err = 1'b1; eof_before_last = 1'b1;
        @(negedge clk);
        eof_before_last = 1'b0; frame_err = 1'b0;
        quiet("R8 rx error no stamp", 3);
        chk("R8 stamp unchanged", {16'd0, stamp}, 32'd39);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule